// File: doc/BRIEF.md
# Temperature Sensor Register and Alarm Block

This block is the device-side register file of a temperature sensor mounted on a memory module. A host reaches eight 16-bit registers through a plain parallel port: it places a pointer, and either reads the selected word combinationally or writes a word with a one-cycle write enable. A converter outside the block delivers 13-bit two's complement samples, one LSB being 0.0625 °C, each marked by a one-cycle valid strobe.

Each accepted sample is stored and compared against three programmable limits: upper, lower and critical. The results are three alarm flags, which the block returns in the top bits of the temperature word. The critical and upper flags switch with a hysteresis band chosen by a two-bit code. The configuration word holds the following controls:

- two sticky lock bits that freeze limit writes;
- a shutdown bit that freezes the reading;
- a mode bit that suppresses every alarm except the critical one.

Top module: `thermSensorRegs`

## Requirements
- R1: After reset the configuration, all three limits, the temperature reading and all alarm flags are zero.
- R2: Pointer 0 reads the capability word, which is 0x0004 when extended range is enabled (bit 2) and 0 otherwise. Pointers 6 and 7 read the manufacturer and device identity parameters. Writes to pointers 0, 5, 6, 7 and to any pointer above 7 change no register. Reads of pointers above 7 return zero.
- R3: Pointers 2, 3 and 4 hold the upper, lower and critical limits. A write keeps only bits 12:0, and bits 15:13 read as zero.
- R4: The configuration word at pointer 1 implements these bits: bit 2 critical-only, bit 6 critical lock, bit 7 event lock, bit 8 shutdown, bits 10:9 hysteresis code. All other bits read as zero.
- R5: While event lock is set, writes to the upper and lower limits are ignored. While critical lock is set, writes to the critical limit are ignored. A lock bit, once set, can be cleared only by reset.
- R6: A configuration write changes the hysteresis code only if both lock bits were clear before that write.
- R7: A sample is accepted when the valid strobe is high and shutdown is clear. After the next clock edge, bits 12:0 of pointer 5 equal the sample. While shutdown is set, the reading is held.
- R8: Bit 15 of pointer 5 is the critical flag. On each accepted sample S, compared as signed against limit C, the flag sets if S > C and clears if S < C − H. Otherwise it keeps its value. H is 0, 24, 48 or 96 LSB for hysteresis codes 0 to 3, that is 0, 1.5, 3 or 6 °C.
- R9: Bit 14 of pointer 5 is the upper flag. It follows the rule of R8 against the upper limit.
- R10: Bit 13 of pointer 5 is the lower flag. On each accepted sample it is set exactly when the sample is below the lower limit, compared as signed and with no hysteresis.
- R11: While critical-only is set, the upper and lower flags read zero from the cycle after the bit is written, and samples do not set them. The critical flag keeps working.
- R12: A sample accepted in the same cycle as a limit or configuration write is judged with the limits, hysteresis and shutdown state held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ptr | input | PTR_W | Register pointer for read and write |
| wrData | input | 16 | Write data |
| wrEn | input | 1 | Write strobe, one cycle per write |
| sampleValid | input | 1 | A new converter sample is present |
| sampleTemp | input | 13 | Converter sample, two's complement, 0.0625 °C per LSB |
| rdData | output | 16 | Word selected by ptr |

## Verification
The collision of interest is a host write landing in the same cycle as a converter sample. The bench drives a critical-limit write together with a sample that lies above the new limit but below the old one. It expects the critical flag to stay clear, and to set only on a repeat of the sample a cycle later. It also sets shutdown in the same cycle as a sample and expects that sample to be stored while the next one is dropped. Around these cases, ramps sweep up and down through all three limits under every hysteresis code, and each reading is compared with a flag model computed from R8 to R10.

// File: rtl/thermPkg.sv
package thermPkg;
  localparam int REG_W  = 16;
  localparam int TEMP_W = 13;

  // Register pointers
  localparam int PTR_CAP   = 0;
  localparam int PTR_CFG   = 1;
  localparam int PTR_UPPER = 2;
  localparam int PTR_LOWER = 3;
  localparam int PTR_CRIT  = 4;
  localparam int PTR_TEMP  = 5;
  localparam int PTR_MFR   = 6;
  localparam int PTR_DEV   = 7;

  // Bit positions
  localparam int CAP_EXT      = 2;
  localparam int CFG_CRITONLY = 2;
  localparam int CFG_CRITLOCK = 6;
  localparam int CFG_EVLOCK   = 7;
  localparam int CFG_SHDN     = 8;
  localparam int CFG_HYST     = 9;

  // Hysteresis step in LSB: code k>0 gives HYST_BASE << k
  localparam int HYST_BASE = 12;

  typedef struct packed {
    logic [1:0] hyst;
    logic       shutdown;
    logic       evLock;
    logic       critLock;
    logic       critOnly;
  } cfgT;

  typedef struct packed {
    logic wrCfg;
    logic wrHyst;
    logic wrUpper;
    logic wrLower;
    logic wrCrit;
    logic takeSample;
  } strobeT;

  function automatic logic [REG_W-1:0] packCfg(input cfgT c);
    logic [REG_W-1:0] w;
    w = '0;
    w[CFG_HYST +: 2]  = c.hyst;
    w[CFG_SHDN]       = c.shutdown;
    w[CFG_EVLOCK]     = c.evLock;
    w[CFG_CRITLOCK]   = c.critLock;
    w[CFG_CRITONLY]   = c.critOnly;
    return w;
  endfunction
endpackage

// File: rtl/thermCtrl.sv
module thermCtrl
  import thermPkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic             wrEn,
  input  logic             sampleValid,
  input  cfgT              cfgQ,
  output strobeT           stb
);
  function automatic logic hit(input logic [PTR_W-1:0] p, input int a);
    return p == PTR_W'(a);
  endfunction

  logic cfgHit;
  logic unusedCfg;
  assign unusedCfg = ^{cfgQ.hyst, cfgQ.critOnly};

  always_comb begin
    cfgHit         = wrEn && hit(ptr, PTR_CFG);
    stb.wrCfg      = cfgHit;
    // hysteresis code only movable while both locks are still open
    stb.wrHyst     = cfgHit && !cfgQ.evLock && !cfgQ.critLock;
    stb.wrUpper    = wrEn && hit(ptr, PTR_UPPER) && !cfgQ.evLock;
    stb.wrLower    = wrEn && hit(ptr, PTR_LOWER) && !cfgQ.evLock;
    stb.wrCrit     = wrEn && hit(ptr, PTR_CRIT)  && !cfgQ.critLock;
    stb.takeSample = sampleValid && !cfgQ.shutdown;
  end
endmodule

// File: rtl/thermDatapath.sv
module thermDatapath
  import thermPkg::*;
#(
  parameter int              PTR_W     = 8,
  parameter logic [REG_W-1:0] MFR_ID   = 16'h1A2B,
  parameter logic [REG_W-1:0] DEV_ID   = 16'h0C01,
  parameter bit              EXT_RANGE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [REG_W-1:0]  wrData,
  input  logic [TEMP_W-1:0] sampleTemp,
  input  logic [PTR_W-1:0]  ptr,
  output cfgT               cfgQ,
  output logic [TEMP_W-1:0] tempQ,
  output logic [TEMP_W-1:0] upperQ,
  output logic [TEMP_W-1:0] lowerQ,
  output logic [TEMP_W-1:0] critQ,
  output logic              critFlag,
  output logic              upFlag,
  output logic              loFlag,
  output logic [REG_W-1:0]  rdData
);
  localparam int CW = TEMP_W + 2;

  logic unusedBits;
  assign unusedBits = ^{wrData[REG_W-1:CFG_HYST+2], wrData[5:3], wrData[1:0]};

  function automatic logic signed [CW-1:0] sx(input logic [TEMP_W-1:0] v);
    return signed'({{(CW-TEMP_W){v[TEMP_W-1]}}, v});
  endfunction

  logic signed [CW-1:0] hyOff, sNew;
  logic critNxt, upNxt, loNxt;

  function automatic logic bandNext(input logic f,
                                    input logic signed [CW-1:0] s,
                                    input logic signed [CW-1:0] lim,
                                    input logic signed [CW-1:0] h);
    if (s > lim)          return 1'b1;
    else if (s < lim - h) return 1'b0;
    else                  return f;
  endfunction

  always_comb begin
    hyOff   = (cfgQ.hyst == 2'd0) ? '0 : signed'(CW'(HYST_BASE) << cfgQ.hyst);
    sNew    = sx(sampleTemp);
    critNxt = bandNext(critFlag, sNew, sx(critQ), hyOff);
    upNxt   = bandNext(upFlag, sNew, sx(upperQ), hyOff);
    loNxt   = sNew < sx(lowerQ);
  end

  // configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (stb.wrCfg) begin
      cfgQ.critOnly <= wrData[CFG_CRITONLY];
      cfgQ.shutdown <= wrData[CFG_SHDN];
      cfgQ.critLock <= cfgQ.critLock | wrData[CFG_CRITLOCK];
      cfgQ.evLock   <= cfgQ.evLock | wrData[CFG_EVLOCK];
      if (stb.wrHyst) cfgQ.hyst <= wrData[CFG_HYST +: 2];
    end
  end

  // limits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ <= '0;
      lowerQ <= '0;
      critQ  <= '0;
    end else begin
      if (stb.wrUpper) upperQ <= wrData[TEMP_W-1:0];
      if (stb.wrLower) lowerQ <= wrData[TEMP_W-1:0];
      if (stb.wrCrit)  critQ  <= wrData[TEMP_W-1:0];
    end
  end

  // reading and alarms
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempQ    <= '0;
      critFlag <= 1'b0;
      upFlag   <= 1'b0;
      loFlag   <= 1'b0;
    end else begin
      if (stb.takeSample) begin
        tempQ    <= sampleTemp;
        critFlag <= critNxt;
        upFlag   <= upNxt;
        loFlag   <= loNxt;
      end
      if (cfgQ.critOnly) begin
        upFlag <= 1'b0;
        loFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (ptr)
      PTR_W'(PTR_CAP):   rdData[CAP_EXT] = EXT_RANGE;
      PTR_W'(PTR_CFG):   rdData = packCfg(cfgQ);
      PTR_W'(PTR_UPPER): rdData = REG_W'(upperQ);
      PTR_W'(PTR_LOWER): rdData = REG_W'(lowerQ);
      PTR_W'(PTR_CRIT):  rdData = REG_W'(critQ);
      PTR_W'(PTR_TEMP):  rdData = {critFlag, upFlag, loFlag, tempQ};
      PTR_W'(PTR_MFR):   rdData = MFR_ID;
      PTR_W'(PTR_DEV):   rdData = DEV_ID;
      default:           rdData = '0;
    endcase
  end
endmodule

// File: rtl/thermSensorRegs.sv
module thermSensorRegs
  import thermPkg::*;
#(
  parameter int               PTR_W     = 8,
  parameter logic [REG_W-1:0] MFR_ID    = 16'h1A2B,
  parameter logic [REG_W-1:0] DEV_ID    = 16'h0C01,
  parameter bit               EXT_RANGE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              wrEn,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleTemp,
  output logic [REG_W-1:0]  rdData
);
  strobeT            stb;
  cfgT               cfgQ;
  logic [TEMP_W-1:0] tempQ, upperQ, lowerQ, critQ;
  logic              critFlag, upFlag, loFlag;

  thermCtrl #(.PTR_W(PTR_W)) i_ctrl (
    .ptr(ptr), .wrEn(wrEn), .sampleValid(sampleValid), .cfgQ(cfgQ), .stb(stb)
  );

  thermDatapath #(
    .PTR_W(PTR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .EXT_RANGE(EXT_RANGE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .sampleTemp(sampleTemp),
    .ptr(ptr), .cfgQ(cfgQ), .tempQ(tempQ), .upperQ(upperQ), .lowerQ(lowerQ),
    .critQ(critQ), .critFlag(critFlag), .upFlag(upFlag), .loFlag(loFlag),
    .rdData(rdData)
  );
endmodule

// File: rtl/thermSensorRegsChk.sv
module thermSensorRegsChk
  import thermPkg::*;
#(
  parameter int PTR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [PTR_W-1:0]  ptr,
  input logic              wrEn,
  input logic [REG_W-1:0]  rdData,
  input cfgT               cfgQ,
  input logic [TEMP_W-1:0] tempQ,
  input logic [TEMP_W-1:0] upperQ,
  input logic [TEMP_W-1:0] lowerQ,
  input logic [TEMP_W-1:0] critQ,
  input logic              upFlag,
  input logic              loFlag
);
  // R5: event lock freezes upper and lower limits
  a_r5_upper_locked: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ptr == PTR_W'(PTR_UPPER) && cfgQ.evLock) |=> $stable(upperQ));
  a_r5_lower_locked: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ptr == PTR_W'(PTR_LOWER) && cfgQ.evLock) |=> $stable(lowerQ));
  a_r5_crit_locked: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ptr == PTR_W'(PTR_CRIT) && cfgQ.critLock) |=> $stable(critQ));
  a_r5_ev_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.evLock |=> cfgQ.evLock);
  a_r5_crit_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.critLock |=> cfgQ.critLock);
  // R6: hysteresis frozen once any lock is set
  a_r6_hyst_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.evLock || cfgQ.critLock) |=> $stable(cfgQ.hyst));
  // R7: shutdown holds the reading
  a_r7_shutdown_hold: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.shutdown |=> $stable(tempQ));
  // R11: critical-only suppresses upper and lower flags
  a_r11_crit_only: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.critOnly |=> (!upFlag && !loFlag));
  // R2: undefined pointers read zero
  a_r2_undef_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ptr > PTR_W'(PTR_DEV)) |-> (rdData == '0));
endmodule

bind thermSensorRegs thermSensorRegsChk #(.PTR_W(PTR_W)) i_chk (
  .clk(clk), .rstN(rstN), .ptr(ptr), .wrEn(wrEn), .rdData(rdData), .cfgQ(cfgQ),
  .tempQ(tempQ), .upperQ(upperQ), .lowerQ(lowerQ), .critQ(critQ),
  .upFlag(upFlag), .loFlag(loFlag)
);

// File: tb/test_thermSensorRegs.sv
`timescale 1ns/1ps
module test_thermSensorRegs;
  import thermPkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  ptr = '0;
  logic [15:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        sampleValid = 1'b0;
  logic [12:0] sampleTemp = '0;
  logic [15:0] rdData;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  // model state
  int mCrit, mUp, mLo, mHyCode;
  bit fC, fU, fL, mCo;

  always #2 clk = ~clk;

  thermSensorRegs i_thermSensorRegs (
    .clk(clk), .rstN(rstN), .ptr(ptr), .wrData(wrData), .wrEn(wrEn),
    .sampleValid(sampleValid), .sampleTemp(sampleTemp), .rdData(rdData)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit we, input int p, input int d, input bit sv, input int s);
    wrEn = we; ptr = 8'(p); wrData = 16'(d); sampleValid = sv; sampleTemp = 13'(s);
    @(posedge clk); #1;
    wrEn = 1'b0; sampleValid = 1'b0;
  endtask

  task automatic rd(input int p, output int v);
    ptr = 8'(p);
    #0.1;
    v = int'(rdData);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    fC = 0; fU = 0; fL = 0; mCo = 0; mHyCode = 0; mCrit = 0; mUp = 0; mLo = 0;
  endtask

  function automatic int hystLsb(input int code);
    // 1.5, 3.0, 6.0 degC at 0.0625 degC per LSB
    return (code == 0) ? 0 : (3 << (code - 1)) * 8;
  endfunction

  function automatic int band(input bit f, input int s, input int lim, input int h);
    if (s > lim) return 1;
    if (s < lim - h) return 0;
    return int'(f);
  endfunction

  function automatic int expWord(input int s);
    return (int'(fC) << 15) | (int'(fU) << 14) | (int'(fL) << 13) | (s & 'h1FFF);
  endfunction

  task automatic modelSample(input int s);
    int h;
    h = hystLsb(mHyCode);
    fC = bit'(band(fC, s, mCrit, h));
    if (mCo) begin
      fU = 0; fL = 0;
    end else begin
      fU = bit'(band(fU, s, mUp, h));
      fL = (s < mLo);
    end
  endtask

  task automatic applySample(input int s, input string req);
    int v;
    step(0, 0, 0, 1, s);
    modelSample(s);
    rd(PTR_TEMP, v);
    chk(req, v, expWord(s));
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int v;
    doReset();

    // R1 reset state
    rd(PTR_CFG, v);   chk("R1 cfg", v, 0);
    rd(PTR_UPPER, v); chk("R1 upper", v, 0);
    rd(PTR_LOWER, v); chk("R1 lower", v, 0);
    rd(PTR_CRIT, v);  chk("R1 crit", v, 0);
    rd(PTR_TEMP, v);  chk("R1 temp", v, 0);

    // R2 read-only and undefined pointers
    foreach (v_arr[i]) ;
    step(1, PTR_CAP, 'hFFFF, 0, 0);
    step(1, PTR_TEMP, 'hFFFF, 0, 0);
    step(1, PTR_MFR, 'hFFFF, 0, 0);
    step(1, PTR_DEV, 'hFFFF, 0, 0);
    step(1, 8, 'hFFFF, 0, 0);
    step(1, 'hFF, 'hFFFF, 0, 0);
    rd(PTR_CAP, v);   chk("R2 cap", v, 'h0004);
    rd(PTR_TEMP, v);  chk("R2 temp untouched", v, 0);
    rd(PTR_MFR, v);   chk("R2 mfr", v, 'h1A2B);
    rd(PTR_DEV, v);   chk("R2 dev", v, 'h0C01);
    rd(PTR_CFG, v);   chk("R2 cfg untouched", v, 0);
    rd(PTR_UPPER, v); chk("R2 upper untouched", v, 0);
    for (int p = 8; p < 256; p += 31) begin
      rd(p, v); chk("R2 undefined read", v, 0);
    end

    // R3 limit width
    step(1, PTR_UPPER, 'hFFFF, 0, 0);
    rd(PTR_UPPER, v); chk("R3 upper mask", v, 'h1FFF);
    // R4 unimplemented config bits
    step(1, PTR_CFG, 'hF83B, 0, 0);
    rd(PTR_CFG, v); chk("R4 unused cfg bits", v, 0);
    step(1, PTR_CFG, 'h0604, 0, 0);
    rd(PTR_CFG, v); chk("R4 cfg fields", v, 'h0604);
    step(1, PTR_CFG, 0, 0, 0);

    // limits for the sweep
    step(1, PTR_CRIT, 200, 0, 0);    mCrit = 200;
    step(1, PTR_UPPER, 100, 0, 0);   mUp = 100;
    step(1, PTR_LOWER, 'hFFCE, 0, 0); mLo = -50;
    rd(PTR_LOWER, v); chk("R3 lower keeps 12:0", v, 'h1FCE);

    // R8 R9 R10 ramps under every hysteresis code
    for (int code = 0; code < 4; code++) begin
      step(1, PTR_CFG, code << 9, 0, 0); mHyCode = code;
      for (int s = -120; s <= 260; s += 4) applySample(s, "R8 R9 R10 ramp up");
      for (int s = 260; s >= -120; s -= 4) applySample(s, "R8 R9 R10 ramp down");
    end

    // R11 critical-only
    applySample(150, "R9 R10 before crit-only");
    step(1, PTR_CFG, 'h0604, 0, 0); mCo = 1; fU = 0; fL = 0;
    step(0, 0, 0, 0, 0);
    rd(PTR_TEMP, v); chk("R11 flags cleared", v, expWord(150));
    applySample(-100, "R11 lower suppressed");
    applySample(250, "R11 crit still active");
    step(1, PTR_CFG, 'h0600, 0, 0); mCo = 0;
    applySample(150, "R8 R9 after crit-only");

    // R12 same-cycle limit write and sample
    step(1, PTR_CFG, 0, 0, 0); mHyCode = 0;
    applySample(100, "R8 setup");
    step(1, PTR_CRIT, 50, 1, 120);
    modelSample(120); mCrit = 50;
    rd(PTR_TEMP, v); chk("R12 sample uses old crit", v, expWord(120));
    applySample(120, "R8 new crit");
    rd(PTR_CRIT, v); chk("R3 crit", v, 50);

    // R12 / R7 shutdown write with sample in same cycle
    step(1, PTR_CFG, 'h0100, 1, 77);
    modelSample(77);
    rd(PTR_TEMP, v); chk("R12 sample with shutdown write", v, expWord(77));
    step(0, 0, 0, 1, 30);
    rd(PTR_TEMP, v); chk("R7 shutdown holds", v, expWord(77));
    step(1, PTR_CFG, 0, 0, 0);
    applySample(30, "R7 resumed");

    // R5 R6 locks
    step(1, PTR_CFG, 'h0280, 0, 0);
    rd(PTR_CFG, v); chk("R6 hyst set with locks open", v, 'h0280);
    step(1, PTR_UPPER, 'h0123, 0, 0);
    rd(PTR_UPPER, v); chk("R5 upper locked", v, 100);
    step(1, PTR_LOWER, 'h0123, 0, 0);
    rd(PTR_LOWER, v); chk("R5 lower locked", v, 'h1FCE);
    step(1, PTR_CRIT, 'h0055, 0, 0);
    rd(PTR_CRIT, v); chk("R5 crit open", v, 'h0055);
    step(1, PTR_CFG, 'h0640, 0, 0);
    rd(PTR_CFG, v); chk("R5 R6 sticky and hyst frozen", v, 'h02C0);
    step(1, PTR_CRIT, 'h0011, 0, 0);
    rd(PTR_CRIT, v); chk("R5 crit locked", v, 'h0055);
    step(1, PTR_CFG, 0, 0, 0);
    rd(PTR_CFG, v); chk("R5 locks survive zero write", v, 'h02C0);
    step(1, PTR_CFG, 'h0100, 0, 0);
    rd(PTR_CFG, v); chk("R4 shutdown writable under locks", v, 'h03C0);

    // R1 reset clears locks
    doReset();
    rd(PTR_CFG, v); chk("R1 locks cleared by reset", v, 0);
    rd(PTR_CRIT, v); chk("R1 crit after reset", v, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  int v_arr[1];
endmodule